// File: doc/BRIEF.md
# Dual-Slope Center-Aligned PWM Timer

This block is a counter that climbs from zero to a selectable ceiling, turns, and falls back to zero, over and over. Two compare channels watch the count. Each channel drives a waveform bit that flips on a match while climbing and flips back on the matching value while falling. The result is a pulse centred in the period. The ceiling is one of three fixed widths (8, 9 or 10 bits), the active compare value of channel A, or a dedicated ceiling register.

Software loads compare values into buffer registers. These reach the comparators only on the tick at which the counter sits at its ceiling, so a period is never changed halfway through. Four event flags record bottom, channel A, channel B and ceiling events. Writing 1 to a flag clears it.

The counter and waveform state advance only when the `tick` enable is high. Register writes take effect on any clock.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: On a tick, the count rises by one while counting up and falls by one while counting down. With `tick` low, the count does not change.
- R2: The ceiling is chosen by control bits [2:0]: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the active channel A compare value, and 4–7 give the ceiling register. On the tick where an up-count is at or above the ceiling, the direction turns to down. On the tick where a down-count is at zero, it turns to up.
- R3: `flags[0]` is set on the tick where the counter is at zero while counting down.
- R4: Each active compare value is loaded from its buffer (address 1 for A, address 2 for B) only on the tick where the counter turns at its ceiling.
- R5: `flags[1]` (A) and `flags[2]` (B) are set on any tick where the count equals that channel's active compare value.
- R6: On the ceiling tick, `flags[1]` is also set when the ceiling comes from channel A, and `flags[3]` is set when the ceiling comes from the ceiling register (address 3).
- R7: A channel in output mode 2 clears its waveform on a match while counting up and sets it on a match while counting down. Mode 3 does the opposite. Channel A's mode is in control bits [4:3] and channel B's in [6:5].
- R8: In output modes 0 and 1, a channel's waveform bit holds its value.
- R9: When the ceiling selection is 0, 1 or 2, a write to a compare buffer zeroes every bit above 8, 9 or 10 bits respectively.
- R10: While the ceiling is below a channel's active compare value, that channel never matches, so its flag stays clear and its output stays static.
- R11: `pin_a` and `pin_b` carry the waveform only while control bit 7 (A) or bit 8 (B) is 1. Otherwise they are 0.
- R12: Writing to address 4 clears each flag whose data bit is 1. Data bits of 0 leave their flags unchanged. An event in the same cycle keeps its flag set.
- R13: After reset, the count is 0 and counting up, and every register, flag, waveform and pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address: 0 control, 1 buffer A, 2 buffer B, 3 ceiling, 4 flag clear |
| wr_data | input | CW | Write data |
| count | output | CW | Current counter value |
| pin_a | output | 1 | Gated waveform of channel A |
| pin_b | output | 1 | Gated waveform of channel B |
| flags | output | 4 | {ceiling, B match, A match, bottom} event flags |

## Verification
The bench builds the block with its default 16-bit counter and 3-bit address.

A small ceiling register value gives many short periods. These make it quick to cover buffer reloads, mode changes, output gating and ceilings placed below a compare value.

The same width also allows full periods in the 8-, 9- and 10-bit fixed modes. In those periods, masked compare writes become visible as matches exactly at the ceiling.

// File: rtl/pwm_dual_slope_timer.sv
module pwm_dual_slope_timer #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count,
  output logic          pin_a,
  output logic          pin_b,
  output logic [3:0]    flags
);
  localparam logic [AW-1:0] ADR_CTRL = AW'(0);
  localparam logic [AW-1:0] ADR_BUFA = AW'(1);
  localparam logic [AW-1:0] ADR_BUFB = AW'(2);
  localparam logic [AW-1:0] ADR_TOP  = AW'(3);
  localparam logic [AW-1:0] ADR_FLAG = AW'(4);

  logic [8:0]    ctrl;
  logic [CW-1:0] buf_a, buf_b, act_a, act_b, top_reg, cnt, top_val, wmask, cnt_n;
  logic          up, up_n, wav_a, wav_b, turn_dn, turn_up, hit_a, hit_b;
  logic [2:0]    top_sel;
  logic [3:0]    set_v, clr_v;

  function automatic logic wave_next(input logic [1:0] m, input logic cur,
                                     input logic hit, input logic dir_up);
    return (hit && m[1]) ? (~dir_up ^ m[0]) : cur;
  endfunction

  assign top_sel = ctrl[2:0];

  always_comb begin
    case (top_sel)
      3'd0:    top_val = CW'(16'h00FF);
      3'd1:    top_val = CW'(16'h01FF);
      3'd2:    top_val = CW'(16'h03FF);
      3'd3:    top_val = act_a;
      default: top_val = top_reg;
    endcase
    wmask = (top_sel < 3'd3) ? top_val : '1;
  end

  assign turn_dn = up && (cnt >= top_val);
  assign turn_up = !up && (cnt == '0);
  assign up_n    = turn_dn ? 1'b0 : (turn_up ? 1'b1 : up);
  assign cnt_n   = (top_val == '0) ? '0 : (up_n ? cnt + CW'(1) : cnt - CW'(1));
  assign hit_a   = (cnt == act_a);
  assign hit_b   = (cnt == act_b);

  assign set_v = tick ? {turn_dn && (top_sel >= 3'd4), hit_b,
                         hit_a || (turn_dn && top_sel == 3'd3), turn_up} : 4'b0;
  assign clr_v = (wr_en && wr_addr == ADR_FLAG) ? wr_data[3:0] : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; up <= 1'b1; act_a <= '0; act_b <= '0;
      wav_a <= 1'b0; wav_b <= 1'b0;
    end else if (tick) begin
      cnt   <= cnt_n;
      up    <= up_n;
      wav_a <= wave_next(ctrl[4:3], wav_a, hit_a, up);
      wav_b <= wave_next(ctrl[6:5], wav_b, hit_b, up);
      if (turn_dn) begin
        act_a <= buf_a;
        act_b <= buf_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; buf_a <= '0; buf_b <= '0; top_reg <= '0; flags <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      if (wr_en) begin
        case (wr_addr)
          ADR_CTRL: ctrl    <= wr_data[8:0];
          ADR_BUFA: buf_a   <= wr_data & wmask;
          ADR_BUFB: buf_b   <= wr_data & wmask;
          ADR_TOP:  top_reg <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign count = cnt;
  assign pin_a = ctrl[7] & wav_a;
  assign pin_b = ctrl[8] & wav_b;
endmodule

// File: rtl/pwm_dual_slope_timer_chk.sv
module pwm_dual_slope_timer_chk #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] count,
  input logic          pin_a,
  input logic [3:0]    flags,
  input logic          up,
  input logic          turn_dn,
  input logic [CW-1:0] act_a,
  input logic [CW-1:0] buf_a,
  input logic [2:0]    top_sel
);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == $past(count) + CW'(1)) || (count == $past(count) - CW'(1)) || (count == '0));

  a_r3_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !up && count == '0) |=> flags[0]);

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && turn_dn) |=> $stable(act_a));

  a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(1) && top_sel == 3'd0) |=> (buf_a[CW-1:8] == '0));

  a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0) && !wr_data[7]) |=> !pin_a);

  a_r12_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(4) && wr_data[3:0] == 4'b0 && !tick) |=> (flags == $past(flags)));
endmodule

bind pwm_dual_slope_timer pwm_dual_slope_timer_chk #(.CW(CW), .AW(AW)) u_chk (.*);

// File: tb/pwm_dual_slope_timer_tb.sv
`timescale 1ns/1ps
module pwm_dual_slope_timer_tb;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] count;
  logic pin_a, pin_b;
  logic [3:0] flags;

  pwm_dual_slope_timer u_dut (.clk, .rst_n, .tick, .wr_en, .wr_addr, .wr_data,
                              .count, .pin_a, .pin_b, .flags);

  always #5 clk = ~clk;

  typedef struct { logic [15:0] c; logic [1:0] p; logic [3:0] f; string r; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_cnt = 0, m_ba = 0, m_bb = 0, m_aa = 0, m_ab = 0, m_top = 0;
  logic [2:0] m_sel = 0;
  logic [1:0] m_ma = 0, m_mb = 0;
  logic m_oea = 0, m_oeb = 0, m_up = 1, m_wa = 0, m_wb = 0;
  logic [3:0] m_f = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (count !== e.c || {pin_b, pin_a} !== e.p || flags !== e.f) begin
        n_bad++;
        $display("FAIL %s: count=%0h exp %0h pins=%b exp %b flags=%b exp %b",
                 e.r, count, e.c, {pin_b, pin_a}, e.p, flags, e.f);
      end
    end
  end

  function automatic logic [15:0] cf(input int sel, input int ma, input int mb,
                                     input bit oea, input bit oeb);
    return {7'b0, oeb, oea, mb[1:0], ma[1:0], sel[2:0]};
  endfunction

  task automatic cyc(input bit t, input bit w, input logic [2:0] a,
                     input logic [15:0] d, input string r);
    logic [15:0] tv, msk;
    logic [3:0] set, clr;
    bit td, tu;
    exp_t e;
    tick = t; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    set = 0; clr = 0;
    tv = (m_sel == 0) ? 16'h00FF : (m_sel == 1) ? 16'h01FF : (m_sel == 2) ? 16'h03FF :
         (m_sel == 3) ? m_aa : m_top;
    if (t) begin
      td = m_up && (m_cnt >= tv);
      tu = !m_up && (m_cnt == 0);
      if (m_cnt == m_aa) begin set[1] = 1; if (m_ma >= 2) m_wa = (m_ma == 2) ? !m_up : m_up; end
      if (m_cnt == m_ab) begin set[2] = 1; if (m_mb >= 2) m_wb = (m_mb == 2) ? !m_up : m_up; end
      if (td && m_sel == 3) set[1] = 1;
      if (td && m_sel >= 4) set[3] = 1;
      if (tu) set[0] = 1;
      if (td) begin m_aa = m_ba; m_ab = m_bb; m_up = 0; end
      else if (tu) m_up = 1;
      m_cnt = (tv == 0) ? 16'h0 : (m_up ? m_cnt + 16'd1 : m_cnt - 16'd1);
    end
    if (w) begin
      msk = (m_sel < 3) ? tv : 16'hFFFF;
      case (a)
        3'd0: begin m_sel = d[2:0]; m_ma = d[4:3]; m_mb = d[6:5]; m_oea = d[7]; m_oeb = d[8]; end
        3'd1: m_ba = d & msk;
        3'd2: m_bb = d & msk;
        3'd3: m_top = d;
        3'd4: clr = d[3:0];
        default: ;
      endcase
    end
    m_f = (m_f & ~clr) | set;
    e.c = m_cnt; e.p = {m_oeb & m_wb, m_oea & m_wa}; e.f = m_f; e.r = r;
    q.push_back(e);
    @(negedge clk);
    tick = 0; wr_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string r);
    cyc(0, 1, a, d, r);
  endtask

  task automatic run(input int n, input string r);
    for (int i = 0; i < n; i++) cyc(1, 0, 3'd0, 16'd0, r);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    cyc(0, 0, 3'd0, 16'd0, "R13");
    wr(3'd3, 16'd6, "R2");
    wr(3'd1, 16'd2, "R4");
    wr(3'd2, 16'd4, "R4");
    wr(3'd0, cf(4, 2, 3, 1, 1), "R2");
    run(40, "R7");
    for (int i = 0; i < 10; i++) begin
      cyc(1, 0, 3'd0, 16'd0, "R1");
      cyc(0, 0, 3'd0, 16'd0, "R1");
    end
    wr(3'd4, 16'h0, "R12");
    wr(3'd4, 16'hF, "R12");
    run(20, "R5");
    wr(3'd0, cf(4, 0, 1, 1, 1), "R8");
    run(20, "R8");
    wr(3'd0, cf(4, 2, 3, 0, 1), "R11");
    run(16, "R11");
    wr(3'd1, 16'd10, "R10");
    wr(3'd0, cf(4, 2, 3, 1, 1), "R10");
    run(16, "R10");
    wr(3'd4, 16'hF, "R10");
    run(28, "R10");
    wr(3'd1, 16'd5, "R6");
    wr(3'd0, cf(3, 2, 3, 1, 1), "R6");
    run(30, "R6");
    for (int i = 0; i < 12; i++) cyc(1, 1, 3'd4, 16'hF, "R12");
    wr(3'd0, cf(0, 2, 3, 1, 1), "R9");
    wr(3'd1, 16'hFFFF, "R9");
    wr(3'd2, 16'h0300, "R9");
    run(600, "R9");
    wr(3'd0, cf(1, 2, 2, 1, 1), "R2");
    wr(3'd2, 16'hFFFF, "R9");
    run(1100, "R2");
    wr(3'd0, cf(2, 3, 2, 1, 1), "R2");
    wr(3'd1, 16'h0100, "R2");
    run(2100, "R2");
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule